// File: doc/BRIEF.md
# Far-End Fault Signalling Unit

This unit sits on the serial code-bit path of a 100 Mb/s fibre link, below the symbol coder and above the line driver. When fibre operation is selected and the local receive signal-detect input reports no light, the unit replaces the outgoing coded stream with a fault marker. The marker is a run of 84 one bits closed by a single zero bit, sent over and over, so that the partner learns that its own transmit direction is broken.

On the receive side the unit watches the incoming bit stream for that same marker. After three back-to-back markers it raises a fault flag and pulls link status down, even while signal detect is good. A received fault never changes what is transmitted. A static enable turns off both generation and the link-down reaction. With fibre operation off, the transmit stream is passed straight through.

Top module: `fef_unit`

## Requirements
- R1: After reset, fault_o is 0, no marker is being sent and tx_bit_o equals tx_bit_i.
- R2: With fiber_en_i low, tx_bit_o equals tx_bit_i in the same cycle, fault_o is 0 and link_o is 0.
- R3: The marker is 84 ones followed by one zero, period 85 bits, repeated back to back. The first bit appears one clock after the send condition becomes true.
- R4: The marker is sent only while fiber_en_i, fef_en_i are high and sig_det_i is low. Otherwise tx_bit_o equals tx_bit_i.
- R5: A marker that has started is always completed. The return to tx_bit_i happens only on the clock after the closing zero.
- R6: A zero received directly after exactly 84 ones is one marker occurrence. A zero after any other run length (83, 85 or more ones) clears the occurrence count.
- R7: fault_o rises on the clock that samples the closing zero of the third consecutive occurrence.
- R8: While fault_o is high, receiving an 85th consecutive one clears fault_o on that clock.
- R9: fault_o clears when 256 bit times pass after the last occurrence without a new one. It is still high after 255.
- R10: link_o is high exactly when fiber_en_i and sig_det_i are high and fault_o is low.
- R11: A received fault leaves tx_bit_o equal to tx_bit_i while sig_det_i is high.
- R12: With fef_en_i low, no marker is sent and no received marker raises fault_o, so link_o follows fiber_en_i and sig_det_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fiber_en_i | input | 1 | Fibre operation selected; low means copper pass-through |
| sig_det_i | input | 1 | Receive signal detect from the optical module |
| fef_en_i | input | 1 | Static enable for fault generation and detection |
| tx_bit_i | input | 1 | Coded transmit bit from the upstream coder |
| rx_bit_i | input | 1 | Coded receive bit from the line |
| tx_bit_o | output | 1 | Transmit bit toward the line |
| fault_o | output | 1 | Far-end fault detected |
| link_o | output | 1 | Link status |

## Verification
On the transmit side, an alternating upstream bit stream is used during marker generation. Because of this, a marker one is told apart from pass-through data on every even bit, and the exact cycle of return after signal detect recovers is visible. Random data is used for the copper and disabled cases. On the receive side, the sequences are built from runs of 83, 84 and 85 ones. These separate an exact-length occurrence from near misses, an interrupted count from a consecutive one, and clearing by an overlong run from clearing by 256 quiet bit times, each sampled at the cycle just before and at the cycle of the change.

// File: rtl/fef_pkg.sv
package fef_pkg;
  localparam int unsigned MARK_ONES_DEF  = 84;
  localparam int unsigned HITS_NEED_DEF  = 3;
  localparam int unsigned QUIET_BITS_DEF = 256;
endpackage

// File: rtl/fef_tx_gen.sv
module fef_tx_gen #(
  parameter int unsigned MARK_ONES = fef_pkg::MARK_ONES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic sig_det_i,
  input  logic tx_bit_i,
  output logic tx_bit_o
);
  localparam int unsigned PW = $clog2(MARK_ONES + 1);

  logic          sending_q;
  logic [PW-1:0] pos_q;
  logic          last_bit;

  assign last_bit = (pos_q == PW'(MARK_ONES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sending_q <= 1'b0;
      pos_q     <= '0;
    end else if (!active_i) begin
      sending_q <= 1'b0;
      pos_q     <= '0;
    end else if (!sending_q) begin
      pos_q <= '0;
      if (!sig_det_i) sending_q <= 1'b1;
    end else if (last_bit) begin
      // boundary: only place a marker may stop or continue
      pos_q     <= '0;
      sending_q <= !sig_det_i;
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign tx_bit_o = (active_i && sending_q) ? !last_bit : tx_bit_i;
endmodule

// File: rtl/fef_rx_det.sv
module fef_rx_det #(
  parameter int unsigned MARK_ONES  = fef_pkg::MARK_ONES_DEF,
  parameter int unsigned HITS_NEED  = fef_pkg::HITS_NEED_DEF,
  parameter int unsigned QUIET_BITS = fef_pkg::QUIET_BITS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic rx_bit_i,
  output logic fault_o
);
  localparam int unsigned RW = $clog2(MARK_ONES + 2);
  localparam int unsigned HW = $clog2(HITS_NEED + 1);
  localparam int unsigned QW = $clog2(QUIET_BITS + 1);

  logic [RW-1:0] run_q;
  logic [HW-1:0] hits_q;
  logic [QW-1:0] quiet_q;
  logic          fault_q;
  logic          hit, long_run, quiet_end;

  assign hit       = !rx_bit_i && (run_q == RW'(MARK_ONES));
  assign long_run  =  rx_bit_i && (run_q == RW'(MARK_ONES));
  assign quiet_end = !hit && (quiet_q == QW'(QUIET_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      hits_q  <= '0;
      quiet_q <= '0;
      fault_q <= 1'b0;
    end else if (!active_i) begin
      run_q   <= '0;
      hits_q  <= '0;
      quiet_q <= '0;
      fault_q <= 1'b0;
    end else begin
      if (rx_bit_i) begin
        if (run_q != RW'(MARK_ONES + 1)) run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
        if (!hit)                          hits_q <= '0;
        else if (hits_q != HW'(HITS_NEED)) hits_q <= hits_q + 1'b1;
      end
      if (hit)                                quiet_q <= '0;
      else if (quiet_q != QW'(QUIET_BITS))    quiet_q <= quiet_q + 1'b1;
      if (hit && (hits_q >= HW'(HITS_NEED - 1)))  fault_q <= 1'b1;
      else if (long_run || quiet_end)             fault_q <= 1'b0;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/fef_unit.sv
module fef_unit #(
  parameter int unsigned MARK_ONES  = fef_pkg::MARK_ONES_DEF,
  parameter int unsigned HITS_NEED  = fef_pkg::HITS_NEED_DEF,
  parameter int unsigned QUIET_BITS = fef_pkg::QUIET_BITS_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fiber_en_i,
  input  logic sig_det_i,
  input  logic fef_en_i,
  input  logic tx_bit_i,
  input  logic rx_bit_i,
  output logic tx_bit_o,
  output logic fault_o,
  output logic link_o
);
  logic active;

  assign active = fiber_en_i && fef_en_i;

  fef_tx_gen #(.MARK_ONES(MARK_ONES)) i_tx_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .sig_det_i (sig_det_i),
    .tx_bit_i  (tx_bit_i),
    .tx_bit_o  (tx_bit_o)
  );

  fef_rx_det #(
    .MARK_ONES (MARK_ONES),
    .HITS_NEED (HITS_NEED),
    .QUIET_BITS(QUIET_BITS)
  ) i_rx_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .rx_bit_i (rx_bit_i),
    .fault_o  (fault_o)
  );

  assign link_o = fiber_en_i && sig_det_i && !fault_o;
endmodule

// File: rtl/fef_unit_chk.sv
module fef_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fiber_en_i,
  input logic sig_det_i,
  input logic fef_en_i,
  input logic tx_bit_i,
  input logic rx_bit_i,
  input logic tx_bit_o,
  input logic fault_o,
  input logic link_o
);
  assert_copper_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiber_en_i |-> (tx_bit_o == tx_bit_i) && !link_o);

  assert_disabled_no_mark_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fef_en_i |-> tx_bit_o == tx_bit_i);

  assert_disabled_no_fault_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fef_en_i |=> !fault_o);

  assert_link_terms_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o |-> fiber_en_i && sig_det_i && !fault_o);

  assert_rise_on_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(!rx_bit_i));

  assert_rx_keeps_tx_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_det_i && $past(sig_det_i) && $past(sig_det_i, 2) && $past(rst_ni, 2) && fault_o
     && $past(fault_o)) |-> tx_bit_o == tx_bit_i);
endmodule

bind fef_unit fef_unit_chk i_fef_unit_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fiber_en_i (fiber_en_i),
  .sig_det_i  (sig_det_i),
  .fef_en_i   (fef_en_i),
  .tx_bit_i   (tx_bit_i),
  .rx_bit_i   (rx_bit_i),
  .tx_bit_o   (tx_bit_o),
  .fault_o    (fault_o),
  .link_o     (link_o)
);

// File: tb/test_fef_unit.sv
module test_fef_unit;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fiber_en_i = 1'b0, sig_det_i = 1'b1, fef_en_i = 1'b1;
  logic tx_bit_i = 1'b0, rx_bit_i = 1'b0;
  logic tx_bit_o, fault_o, link_o;
  int   n_checks = 0, n_errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  fef_unit i_fef_unit (
    .clk_i(clk), .rst_ni(rst_ni), .fiber_en_i(fiber_en_i), .sig_det_i(sig_det_i),
    .fef_en_i(fef_en_i), .tx_bit_i(tx_bit_i), .rx_bit_i(rx_bit_i),
    .tx_bit_o(tx_bit_o), .fault_o(fault_o), .link_o(link_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one received bit: driven at negedge, taken at next posedge, observed 1 ns later
  task automatic rx_bit(input logic b);
    @(negedge clk);
    rx_bit_i = b;
    tx_bit_i = 1'($urandom);
    #1;
    check("R11 tx unchanged by rx", tx_bit_o, tx_bit_i);
    @(posedge clk);
    #1;
  endtask

  task automatic rx_run(input int ones);
    for (int i = 0; i < ones; i++) rx_bit(1'b1);
    rx_bit(1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    check("R1 fault after reset", fault_o, 0);
    tx_bit_i = 1'b1; #1;
    check("R1 tx passes after reset", tx_bit_o, 1);

    // R2 copper pass-through, even with signal detect low
    sig_det_i = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      tx_bit_i = 1'($urandom);
      rx_bit_i = 1'($urandom);
      #1;
      check("R2 copper tx", tx_bit_o, tx_bit_i);
      check("R2 copper link", link_o, 0);
      check("R2 copper fault", fault_o, 0);
    end
    rx_bit_i = 1'b0;

    // R10 good fibre link
    @(negedge clk);
    sig_det_i = 1'b1; fiber_en_i = 1'b1;
    #1;
    check("R10 link up", link_o, 1);
    check("R4 data with sd high", tx_bit_o, tx_bit_i);

    // R12 enable low: no marker although sd low
    @(negedge clk);
    fef_en_i = 1'b0; sig_det_i = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      tx_bit_i = 1'($urandom);
      #1;
      check("R12 no marker when disabled", tx_bit_o, tx_bit_i);
    end
    check("R10 link down sd low", link_o, 0);
    @(negedge clk);
    sig_det_i = 1'b1; fef_en_i = 1'b1;

    // R3/R4/R5 marker generation, sd drops then recovers mid-marker
    @(negedge clk);
    tx_bit_i = 1'b0;
    sig_det_i = 1'b0;
    #1;
    check("R3 no marker before clock", tx_bit_o, 0);
    @(posedge clk);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      tx_bit_i = k[0];
      if (k == 210) sig_det_i = 1'b1;
      #1;
      if (k < 255) check((k < 210) ? "R3 marker bit" : "R5 marker completes",
                         tx_bit_o, ((k % 85) != 84) ? 1 : 0);
      else         check("R5 data after boundary", tx_bit_o, k[0]);
      if (k == 100) check("R10 link down during sd loss", link_o, 0);
    end

    // R6/R7 receive detection
    rx_run(84); rx_run(84);
    check("R7 no fault after two", fault_o, 0);
    rx_run(83);
    rx_run(84); rx_run(84);
    check("R6 short run resets count", fault_o, 0);
    rx_run(85);
    rx_run(84); rx_run(84);
    check("R6 long run resets count", fault_o, 0);
    rx_run(84);
    check("R7 fault after three", fault_o, 1);
    check("R10 link down on fault", link_o, 0);

    // R8 overlong run clears
    for (int i = 0; i < 84; i++) rx_bit(1'b1);
    check("R8 still set after 84 ones", fault_o, 1);
    rx_bit(1'b1);
    check("R8 cleared at 85th one", fault_o, 0);
    check("R10 link back", link_o, 1);
    rx_bit(1'b0);

    // R9 quiet timeout
    rx_run(84); rx_run(84); rx_run(84);
    check("R9 fault set", fault_o, 1);
    for (int i = 0; i < 255; i++) rx_bit(1'b0);
    check("R9 still set at 255", fault_o, 1);
    rx_bit(1'b0);
    check("R9 cleared at 256", fault_o, 0);

    // R9 ongoing markers keep fault alive beyond 256 bits
    rx_run(84); rx_run(84); rx_run(84); rx_run(84); rx_run(84); rx_run(84);
    check("R9 held by markers", fault_o, 1);

    // R12 disabling clears and blocks detection
    @(negedge clk);
    fef_en_i = 1'b0;
    @(posedge clk); #1;
    check("R12 fault cleared by disable", fault_o, 0);
    rx_run(84); rx_run(84); rx_run(84); rx_run(84);
    check("R12 no fault when disabled", fault_o, 0);
    check("R12 link follows sd", link_o, 1);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule